// File: doc/BRIEF.md
# Filtered CAN Receive Frame Queue

This block sits between a CAN receive engine and a host. Each time the engine completes a frame, it hands over a word-parallel record (identifier, data length code and eight data bytes) in one cycle. With the record come one match bit per acceptance filter and one enable bit per filter. The block keeps the frame if any enabled filter matched it. It also keeps every frame when no filter is enabled at all. A kept frame is appended to a first-in first-out store whose depth is a parameter of up to 64 frames.

The host takes frames out one at a time with a single-cycle read request, and the oldest frame appears on the read outputs one cycle later. The block drives a not-empty level. It also drives three single-cycle event pulses, intended to be latched by an interrupt register elsewhere: frame stored, frame lost to a full store, and read of an empty store. The CAN protocol engine, bit timing and the register bus are outside this block.

Top module: `can_rx_queue`

## Requirements
- R1: With at least one filter enabled, an offered frame (`wr_valid` high) whose `filt_hit & filt_en` is non-zero is stored. Bit i of `filt_hit` means filter i matched, and bit i of `filt_en` means filter i is enabled.
- R2: When `filt_en` is all zero, every offered frame is stored, whatever `filt_hit` holds.
- R3: A frame offered with a non-zero `filt_en` and a zero `filt_hit & filt_en` is discarded. It raises no event and leaves the stored contents unchanged.
- R4: Frames leave in the order they were stored, and the store holds up to DEPTH frames (1 ≤ DEPTH ≤ 64).
- R5: `not_empty` is high in every cycle in which at least one frame is held. It reflects each store or removal from the cycle after the clock edge that performs it.
- R6: A kept frame offered while DEPTH frames are held, with no read in the same cycle, is dropped. The stored contents stay unchanged, and `evt_ovfl` pulses high for one cycle after that edge.
- R7: A read request while the store is empty leaves the read position unchanged. One cycle later, `rd_id`, `rd_dlc` and `rd_data` are all zero, `rd_valid` is low and `evt_unfl` pulses for one cycle.
- R8: `evt_rxok` pulses high for exactly the one cycle after each edge that stores a frame.
- R9: A read request while the store is non-empty removes the oldest frame. That frame appears on the read outputs with `rd_valid` high one cycle later.
- R10: When the store is full, a read and a kept frame in the same cycle both take effect: the oldest frame is read out and the new one is stored with no overflow.
- R11: A synchronous active-low reset empties the store, clears the read and write positions and holds every event low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | A completed frame is offered this cycle |
| wr_id | input | 29 | Identifier of the offered frame |
| wr_dlc | input | 4 | Data length code of the offered frame |
| wr_data | input | 64 | Data bytes of the offered frame |
| filt_hit | input | NUM_FILT | Per-filter match result for the offered frame |
| filt_en | input | NUM_FILT | Per-filter enable |
| rd_req | input | 1 | Host read request, one frame per cycle |
| rd_valid | output | 1 | Read outputs carry a frame taken by the previous request |
| rd_id | output | 29 | Identifier of the frame read |
| rd_dlc | output | 4 | Data length code of the frame read |
| rd_data | output | 64 | Data bytes of the frame read |
| not_empty | output | 1 | At least one frame is held |
| evt_rxok | output | 1 | One-cycle pulse: a frame was stored |
| evt_ovfl | output | 1 | One-cycle pulse: a kept frame was lost because the store was full |
| evt_unfl | output | 1 | One-cycle pulse: a read found the store empty |

## Verification
The hardest situation to reach is a kept frame arriving in the same cycle as a read while the store holds exactly DEPTH frames. Here the push is allowed only because the pop frees a slot, and the read and write positions point at the same entry. Random traffic rarely lines up all three conditions. So a directed phase fills the store to the brim and then issues simultaneous reads and kept frames for several cycles, comparing each frame read out with the bench's model. A random phase biased toward writing then hovers near full, and a second phase biased toward reading hovers near empty. Together they mix overflow, underflow and filter rejection with ordinary traffic.

// File: rtl/rxq_pkg.sv
// Shared widths and the frame record for the filtered receive queue.
// Assumes standard-format and extended identifiers share one 29-bit field.
package rxq_pkg;
    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rxq_frame_t;

    localparam int FRAME_W = $bits(rxq_frame_t);
endpackage

// File: rtl/rxq_accept.sv
// Acceptance decision: keeps an offered frame when any enabled filter hit,
// or when no filter is enabled at all. Purely combinational.
// Assumes hit and enable bits are valid in the same cycle as wr_valid.
module rxq_accept #(
    parameter int NUM_FILT = 4
) (
    input  logic                wr_valid,
    input  logic [NUM_FILT-1:0] filt_hit,
    input  logic [NUM_FILT-1:0] filt_en,
    output logic                keep
);
    logic [NUM_FILT-1:0] pass_vec;

    // One pass bit per filter: enabled and matched
    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        assign pass_vec[g] = filt_hit[g] & filt_en[g];
    end

    // Keep on any pass, or on everything when all filters are off
    always_comb begin
        keep = wr_valid && ((filt_en == '0) || (pass_vec != '0));
    end
endmodule

// File: rtl/rxq_ctrl.sv
// Position and occupancy control for the receive queue. Decides push, pop,
// overflow and underflow for each cycle and registers the event pulses.
// Assumes DEPTH between 1 and 64; positions wrap at DEPTH, not at a power of 2.
module rxq_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          keep,
    input  logic          rd_req,
    output logic          push,
    output logic          pop,
    output logic          under,
    output logic [AW-1:0] wr_pos,
    output logic [AW-1:0] rd_pos,
    output logic [CW-1:0] fill,
    output logic          not_empty,
    output logic          evt_rxok,
    output logic          evt_ovfl,
    output logic          evt_unfl
);
    logic full, empty, drop;

    // Next position with wrap at DEPTH-1
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-cycle decisions from the current occupancy
    always_comb begin
        full  = (fill == CW'(DEPTH));
        empty = (fill == '0);
        pop   = rd_req && !empty;
        under = rd_req && empty;
        push  = keep && (!full || pop);
        drop  = keep && full && !pop;
    end

    // Positions and occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pos <= '0;
            rd_pos <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_pos <= bump(wr_pos);
            if (pop)  rd_pos <= bump(rd_pos);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Registered one-cycle event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_rxok <= 1'b0;
            evt_ovfl <= 1'b0;
            evt_unfl <= 1'b0;
        end else begin
            evt_rxok <= push;
            evt_ovfl <= drop;
            evt_unfl <= under;
        end
    end

    // Occupancy level flag
    always_comb begin
        not_empty = (fill != '0);
    end
endmodule

// File: rtl/rxq_store.sv
// Frame storage array with one write port and a registered read port.
// An underflow read loads an all-zero record. Storage itself is not reset.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 97,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic          under,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic          rvalid
);
    logic [W-1:0] mem [DEPTH];

    // Write an accepted frame into its slot
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read register: oldest frame, zeros on underflow, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            if (re)         rdata <= mem[raddr];
            else if (under) rdata <= '0;
        end
    end
endmodule

// File: rtl/can_rx_queue.sv
// Top of the filtered receive queue: acceptance decision, control and
// storage. Frames enter word-parallel in one cycle and leave one per request.
// Assumes DEPTH between 1 and 64 and at least one filter.
module can_rx_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int NUM_FILT = 4,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [ID_W-1:0]     wr_id,
    input  logic [DLC_W-1:0]    wr_dlc,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [NUM_FILT-1:0] filt_hit,
    input  logic [NUM_FILT-1:0] filt_en,
    input  logic                rd_req,
    output logic                rd_valid,
    output logic [ID_W-1:0]     rd_id,
    output logic [DLC_W-1:0]    rd_dlc,
    output logic [DATA_W-1:0]   rd_data,
    output logic                not_empty,
    output logic                evt_rxok,
    output logic                evt_ovfl,
    output logic                evt_unfl
);
    logic          keep, push, pop, under;
    logic [AW-1:0] wr_pos, rd_pos;
    logic [CW-1:0] fill_cnt;
    rxq_frame_t    in_rec, out_rec;

    // Pack the offered frame into one record
    always_comb begin
        in_rec.id   = wr_id;
        in_rec.dlc  = wr_dlc;
        in_rec.data = wr_data;
    end

    rxq_accept #(.NUM_FILT(NUM_FILT)) u_accept (
        .wr_valid (wr_valid),
        .filt_hit (filt_hit),
        .filt_en  (filt_en),
        .keep     (keep)
    );

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .keep      (keep),
        .rd_req    (rd_req),
        .push      (push),
        .pop       (pop),
        .under     (under),
        .wr_pos    (wr_pos),
        .rd_pos    (rd_pos),
        .fill      (fill_cnt),
        .not_empty (not_empty),
        .evt_rxok  (evt_rxok),
        .evt_ovfl  (evt_ovfl),
        .evt_unfl  (evt_unfl)
    );

    rxq_store #(.DEPTH(DEPTH), .W(FRAME_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (push),
        .waddr  (wr_pos),
        .wdata  (in_rec),
        .re     (pop),
        .under  (under),
        .raddr  (rd_pos),
        .rdata  (out_rec),
        .rvalid (rd_valid)
    );

    // Unpack the read record onto the output fields
    always_comb begin
        rd_id   = out_rec.id;
        rd_dlc  = out_rec.dlc;
        rd_data = out_rec.data;
    end
endmodule

// File: rtl/rxq_chk.sv
// Protocol checks for the filtered receive queue, bound to the top module.
module rxq_chk #(
    parameter int DEPTH    = 16,
    parameter int NUM_FILT = 4,
    parameter int CW       = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic [NUM_FILT-1:0] filt_hit,
    input logic [NUM_FILT-1:0] filt_en,
    input logic                rd_req,
    input logic                rd_valid,
    input logic                rd_id_nz,
    input logic                not_empty,
    input logic                evt_rxok,
    input logic                evt_ovfl,
    input logic                evt_unfl,
    input logic [CW-1:0]       fill_cnt
);
    // R3
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_valid) && ($past(filt_en) != '0) && (($past(filt_hit) & $past(filt_en)) == '0))
        |-> (!evt_rxok && !evt_ovfl));
    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));
    // R5
    rxok_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rxok |-> not_empty);
    // R6
    ovfl_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovfl |-> (($past(fill_cnt) == CW'(DEPTH)) && (fill_cnt == CW'(DEPTH)) && $past(wr_valid)));
    // R7
    unfl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_unfl |-> (!rd_valid && !rd_id_nz && $past(rd_req) && !$past(not_empty)));
    // R8
    rxok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_rxok, evt_ovfl}));
    // R9
    rdvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_req) && $past(not_empty)));
endmodule

bind can_rx_queue rxq_chk #(.DEPTH(DEPTH), .NUM_FILT(NUM_FILT), .CW(CW)) i_rxq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .filt_hit  (filt_hit),
    .filt_en   (filt_en),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_id_nz  ((rd_id != '0) || (rd_dlc != '0) || (rd_data != '0)),
    .not_empty (not_empty),
    .evt_rxok  (evt_rxok),
    .evt_ovfl  (evt_ovfl),
    .evt_unfl  (evt_unfl),
    .fill_cnt  (fill_cnt)
);

// File: tb/test_can_rx_queue.sv
module test_can_rx_queue;
    import rxq_pkg::*;

    localparam int DEPTH = 16;
    localparam int NF    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ID_W-1:0]   wr_id = '0;
    logic [DLC_W-1:0]  wr_dlc = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [NF-1:0]     filt_hit = '0;
    logic [NF-1:0]     filt_en = '0;
    logic              rd_req = 1'b0;
    logic              rd_valid;
    logic [ID_W-1:0]   rd_id;
    logic [DLC_W-1:0]  rd_dlc;
    logic [DATA_W-1:0] rd_data;
    logic              not_empty, evt_rxok, evt_ovfl, evt_unfl;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    rxq_frame_t model[$];

    always #2 clk = ~clk;

    can_rx_queue #(.DEPTH(DEPTH), .NUM_FILT(NF)) i_can_rx_queue (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_id(wr_id),
        .wr_dlc(wr_dlc), .wr_data(wr_data), .filt_hit(filt_hit),
        .filt_en(filt_en), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data),
        .not_empty(not_empty), .evt_rxok(evt_rxok), .evt_ovfl(evt_ovfl),
        .evt_unfl(evt_unfl)
    );

    function automatic bit accept_fn(input logic [NF-1:0] hit, input logic [NF-1:0] en);
        return (en == '0) || ((hit & en) != '0);
    endfunction

    function automatic rxq_frame_t rand_frame();
        rxq_frame_t f;
        f.id   = ID_W'($urandom);
        f.dlc  = DLC_W'($urandom);
        f.data = {$urandom, $urandom};
        return f;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus; outputs checked at the following negedge
    task automatic step(input logic wv, input rxq_frame_t f, input logic [NF-1:0] hit,
                        input logic [NF-1:0] en, input logic rd, input string tag);
        bit acc, e_push, e_pop, e_ovfl, e_unfl;
        rxq_frame_t e_rd;
        wr_valid = wv; wr_id = f.id; wr_dlc = f.dlc; wr_data = f.data;
        filt_hit = hit; filt_en = en; rd_req = rd;
        acc    = wv && accept_fn(hit, en);
        e_pop  = rd && (model.size() > 0);
        e_unfl = rd && (model.size() == 0);
        e_push = acc && ((model.size() < DEPTH) || e_pop);
        e_ovfl = acc && !e_push;
        e_rd   = e_pop ? model[0] : '0;
        if (e_pop)  void'(model.pop_front());
        if (e_push) model.push_back(f);
        @(negedge clk);
        chk("R9", "rd_valid", 128'(rd_valid), 128'(e_pop));
        if (e_pop)  chk("R4", "read record", 128'({rd_id, rd_dlc, rd_data}), 128'(e_rd));
        if (e_unfl) chk("R7", "underflow record", 128'({rd_id, rd_dlc, rd_data}), 128'(0));
        chk("R8", "evt_rxok", 128'(evt_rxok), 128'(e_push));
        chk("R6", "evt_ovfl", 128'(evt_ovfl), 128'(e_ovfl));
        chk("R7", "evt_unfl", 128'(evt_unfl), 128'(e_unfl));
        chk("R5", "not_empty", 128'(not_empty), 128'(model.size() > 0));
        if (tag != "") chk(tag, "stored", 128'(evt_rxok), 128'(e_push));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 1'b0, "");
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
        repeat (3) @(negedge clk);
        model.delete();
        chk("R11", "not_empty in reset", 128'(not_empty), 128'(0));
        chk("R11", "events in reset", 128'({evt_rxok, evt_ovfl, evt_unfl, rd_valid}), 128'(0));
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        do_reset();
        // R7: read of empty store
        step(1'b0, '0, '0, '0, 1'b1, "");
        // R1: enabled filter hit stores
        step(1'b1, rand_frame(), 4'b0100, 4'b0110, 1'b0, "R1");
        // R2: no filter enabled stores
        step(1'b1, rand_frame(), 4'b0000, 4'b0000, 1'b0, "R2");
        // R3: enabled filters, no hit on enabled ones, discarded
        step(1'b1, rand_frame(), 4'b1001, 4'b0110, 1'b0, "R3");
        idle(1);
        // drain and confirm the rejected frame never appears
        step(1'b0, '0, '0, '0, 1'b1, "");
        step(1'b0, '0, '0, '0, 1'b1, "");
        step(1'b0, '0, '0, '0, 1'b1, "R3");
        // R4 fill to capacity, then R6 overflow
        for (int i = 0; i < DEPTH; i++) step(1'b1, rand_frame(), '0, '0, 1'b0, "R4");
        step(1'b1, rand_frame(), 4'b0001, 4'b0001, 1'b0, "R6");
        step(1'b1, rand_frame(), '0, '0, 1'b0, "R6");
        // R10: read and push together on a full store
        for (int i = 0; i < 5; i++) step(1'b1, rand_frame(), '0, '0, 1'b1, "R10");
        // R11: reset while holding frames, then empty read
        do_reset();
        step(1'b0, '0, '0, '0, 1'b1, "R11");
        // random traffic: write-heavy then read-heavy
        for (int i = 0; i < 4000; i++) begin
            bit wv, rd;
            wv = ($urandom % 4) != 0;
            rd = (i < 2000) ? (($urandom % 4) == 0) : (($urandom % 3) != 0);
            step(wv, rand_frame(), NF'($urandom), (($urandom % 3) == 0) ? '0 : NF'($urandom), rd, "");
        end
        while (model.size() > 0) step(1'b0, '0, '0, '0, 1'b1, "");
        step(1'b0, '0, '0, '0, 1'b1, "R7");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule